// File: doc/BRIEF.md
# Two-Manager Same-Line Upgrade Serializer

This block sits inside a small coherent interconnect that joins two caching managers. Either manager can ask to upgrade one of its cache lines to exclusive ownership. The block grants each upgrade, then sends an invalidating snoop to the other manager. It waits for that manager to acknowledge the snoop, and only then returns the completion response to the requester. All channels use valid/ready handshakes, except the snoop acknowledgement, which is a one-cycle pulse. A request stays in flight from its accepting handshake until its response handshake.

Two upgrades that name the same 64-byte line are handled strictly one after the other. The later one is held off until the earlier one has delivered its response. The snoop that the later one then issues therefore reaches the manager that has just become the owner. Upgrades to different lines are independent and may be in flight together. The block also keeps an ownership record for a single tracked line: the line of the most recently acknowledged upgrade, and each manager's state for that line. The managers can read this record through output ports.

Top module: `coh_line_serializer`

## Requirements
- R1: Line identity is the address with bits [5:0] dropped. Two requests whose addresses differ only in bits [5:0] target the same line. Requests that differ in any bit above bit 5 target different lines.
- R2: Two requests to the same line are never accepted in the same cycle. A request to a line held by the other manager's in-flight upgrade keeps its ready low until that upgrade's response handshake has completed.
- R3: The two manager state outputs are never both Unique at the same time.
- R4: When manager i's request is accepted, the snoop valid to the other manager rises in the next cycle. The snoop address is the requested line with bits [5:0] zero. Snoop valid and snoop address hold steady until snoop ready is seen.
- R5: The response valid to a requester rises only in the cycle after the snooped manager's acknowledgement pulse. An acknowledgement is only sampled after the snoop handshake. Response valid holds until response ready, and that handshake ends the request.
- R6: Priority starts with manager 0 and passes to the other manager in any cycle where exactly one manager is accepted. When both managers present requests to the same line in the same cycle, the manager holding priority is accepted and the other is stalled.
- R7: Requests to different lines from both managers are accepted in the same cycle when both managers are idle.
- R8: Each state output uses the encoding Invalid=2'b00, Shared=2'b01, Unique=2'b10. On an acknowledgement, the cycle after the pulse shows the requester Unique, the snooped manager Invalid, and the tracked line equal to the request address bits [31:6]. If both managers' acknowledgements arrive in the same cycle, manager 1's request determines all three.
- R9: After reset, both states are Invalid, the tracked line is zero, no snoop or response valid is high, and manager 0 holds priority.
- R10: A stalled same-line request is accepted in the cycle that follows the earlier request's response handshake. Its snoop goes to the manager that has just become Unique.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| m0ReqValid | input | 1 | Manager 0 upgrade request valid |
| m0ReqReady | output | 1 | Manager 0 request accepted |
| m0ReqAddr | input | ADDR_W | Manager 0 request byte address |
| m0RspValid | output | 1 | Manager 0 completion valid |
| m0RspReady | input | 1 | Manager 0 completion ready |
| m0SnpValid | output | 1 | Invalidating snoop valid to manager 0 |
| m0SnpReady | input | 1 | Manager 0 snoop ready |
| m0SnpAddr | output | ADDR_W | Line-aligned snoop address to manager 0 |
| m0SnpAck | input | 1 | Manager 0 snoop acknowledgement pulse |
| m1ReqValid | input | 1 | Manager 1 upgrade request valid |
| m1ReqReady | output | 1 | Manager 1 request accepted |
| m1ReqAddr | input | ADDR_W | Manager 1 request byte address |
| m1RspValid | output | 1 | Manager 1 completion valid |
| m1RspReady | input | 1 | Manager 1 completion ready |
| m1SnpValid | output | 1 | Invalidating snoop valid to manager 1 |
| m1SnpReady | input | 1 | Manager 1 snoop ready |
| m1SnpAddr | output | ADDR_W | Line-aligned snoop address to manager 1 |
| m1SnpAck | input | 1 | Manager 1 snoop acknowledgement pulse |
| m0LineState | output | 2 | Manager 0 state for the tracked line |
| m1LineState | output | 2 | Manager 1 state for the tracked line |
| trackedLine | output | ADDR_W-6 | Line number of the tracked line |

## Verification
The case that is hardest to reach is a same-line race that lines up exactly at the boundary. The stalled manager must still be presenting its request in the very cycle after the other manager's response handshake. It must also be the manager that now holds priority, or its snoop must be aimed at a manager that became Unique only one cycle earlier. Random request timing seldom produces that alignment. Directed sequences therefore hold both managers ready at full rate and issue a tie from reset, followed by a stall-and-resume. They also cover a same-cycle double acknowledgement on two distinct lines and a tie that follows a lone grant. A random phase then draws addresses from a small pool that mixes shared lines with offsets inside one line, and it varies snoop ready, response ready and acknowledgement delay.

// File: rtl/coh_ser_pkg.sv
package coh_ser_pkg;

  // per-manager ownership of the tracked line
  typedef enum logic [1:0] {
    LS_INV = 2'b00,
    LS_SHR = 2'b01,
    LS_UNQ = 2'b10
  } lineState_t;

  // one engine per requesting manager
  typedef enum logic [1:0] {
    EN_IDLE,
    EN_SNOOP,
    EN_WAIT,
    EN_RESP
  } engState_t;

  // strobes from control to datapath, bit index = requesting manager
  typedef struct packed {
    logic [1:0] capture;  // latch the request line on acceptance
    logic [1:0] commit;   // snoop acknowledged: update ownership
  } ctlStrobes_t;

endpackage

// File: rtl/coh_ser_datapath.sv
module coh_ser_datapath
  import coh_ser_pkg::*;
#(
  parameter  int ADDR_W   = 32,
  parameter  int LINE_OFS = 6,
  localparam int LINE_W   = ADDR_W - LINE_OFS
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [1:0][ADDR_W-1:0]       reqAddr,
  input  ctlStrobes_t                  strobes,
  output logic [1:0][LINE_W-1:0]       heldLine,
  output logic [1:0]                   hitHeld,
  output logic                         reqSameLine,
  output logic [1:0][1:0]              lineState,
  output logic [LINE_W-1:0]            trackedLine
);

  logic [1:0][LINE_W-1:0] reqLine;

  for (genvar g = 0; g < 2; g++) begin : g_eng
    localparam bit OTHER = (g == 0);

    assign reqLine[g] = reqAddr[g][ADDR_W-1:LINE_OFS];

    // line of the in-flight request, kept until the engine is reused
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        heldLine[g] <= '0;
      end else if (strobes.capture[g]) begin
        heldLine[g] <= reqLine[g];
      end
    end

    // incoming request of manager g against the other engine's line
    assign hitHeld[g] = (reqLine[g] == heldLine[OTHER]);
  end

  assign reqSameLine = (reqLine[0] == reqLine[1]);

  // ownership record; commit of engine 1 is written last and wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lineState[0] <= LS_INV;
      lineState[1] <= LS_INV;
      trackedLine  <= '0;
    end else begin
      if (strobes.commit[0]) begin
        lineState[0] <= LS_UNQ;
        lineState[1] <= LS_INV;
        trackedLine  <= heldLine[0];
      end
      if (strobes.commit[1]) begin
        lineState[1] <= LS_UNQ;
        lineState[0] <= LS_INV;
        trackedLine  <= heldLine[1];
      end
    end
  end

endmodule

// File: rtl/coh_ser_control.sv
module coh_ser_control
  import coh_ser_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  reqValid,
  input  logic [1:0]  hitHeld,
  input  logic        reqSameLine,
  input  logic [1:0]  snpReady,
  input  logic [1:0]  snpAck,
  input  logic [1:0]  rspReady,
  output logic [1:0]  reqReady,
  output logic [1:0]  snpValid,
  output logic [1:0]  rspValid,
  output ctlStrobes_t strobes
);

  logic [1:0] busy;
  logic [1:0] cand;
  logic [1:0] grant;
  logic       tie;
  logic       prio;   // manager that wins a same-line tie

  for (genvar g = 0; g < 2; g++) begin : g_eng
    localparam bit OTHER = (g == 0);
    engState_t engQ;

    assign busy[g] = (engQ != EN_IDLE);
    // stall while the other engine owns the same line
    assign cand[g] = reqValid[g] && !busy[g] && !(busy[OTHER] && hitHeld[g]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        engQ <= EN_IDLE;
      end else begin
        unique case (engQ)
          EN_IDLE:  if (grant[g])          engQ <= EN_SNOOP;
          EN_SNOOP: if (snpReady[OTHER])   engQ <= EN_WAIT;
          EN_WAIT:  if (snpAck[OTHER])     engQ <= EN_RESP;
          EN_RESP:  if (rspReady[g])       engQ <= EN_IDLE;
          default:                         engQ <= EN_IDLE;
        endcase
      end
    end

    // engine g snoops the other manager
    assign snpValid[OTHER]   = (engQ == EN_SNOOP);
    assign rspValid[g]       = (engQ == EN_RESP);
    assign strobes.commit[g] = (engQ == EN_WAIT) && snpAck[OTHER];
  end

  assign tie      = cand[0] && cand[1] && reqSameLine;
  assign grant[0] = cand[0] && !(tie && prio);
  assign grant[1] = cand[1] && !(tie && !prio);

  assign reqReady        = grant;
  assign strobes.capture = grant;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prio <= 1'b0;
    end else if (grant[0] ^ grant[1]) begin
      prio <= grant[0];
    end
  end

endmodule

// File: rtl/coh_line_serializer.sv
module coh_line_serializer
  import coh_ser_pkg::*;
#(
  parameter  int ADDR_W   = 32,
  parameter  int LINE_OFS = 6,
  localparam int LINE_W   = ADDR_W - LINE_OFS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              m0ReqValid,
  output logic              m0ReqReady,
  input  logic [ADDR_W-1:0] m0ReqAddr,
  output logic              m0RspValid,
  input  logic              m0RspReady,
  output logic              m0SnpValid,
  input  logic              m0SnpReady,
  output logic [ADDR_W-1:0] m0SnpAddr,
  input  logic              m0SnpAck,
  input  logic              m1ReqValid,
  output logic              m1ReqReady,
  input  logic [ADDR_W-1:0] m1ReqAddr,
  output logic              m1RspValid,
  input  logic              m1RspReady,
  output logic              m1SnpValid,
  input  logic              m1SnpReady,
  output logic [ADDR_W-1:0] m1SnpAddr,
  input  logic              m1SnpAck,
  output logic [1:0]        m0LineState,
  output logic [1:0]        m1LineState,
  output logic [LINE_W-1:0] trackedLine
);

  ctlStrobes_t             strobes;
  logic [1:0][ADDR_W-1:0]  reqAddr;
  logic [1:0][LINE_W-1:0]  heldLine;
  logic [1:0]              hitHeld;
  logic                    reqSameLine;
  logic [1:0][1:0]         lineState;
  logic [1:0]              reqReady;
  logic [1:0]              snpValid;
  logic [1:0]              rspValid;

  assign reqAddr[0] = m0ReqAddr;
  assign reqAddr[1] = m1ReqAddr;

  coh_ser_control ctl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    ({m1ReqValid, m0ReqValid}),
    .hitHeld     (hitHeld),
    .reqSameLine (reqSameLine),
    .snpReady    ({m1SnpReady, m0SnpReady}),
    .snpAck      ({m1SnpAck, m0SnpAck}),
    .rspReady    ({m1RspReady, m0RspReady}),
    .reqReady    (reqReady),
    .snpValid    (snpValid),
    .rspValid    (rspValid),
    .strobes     (strobes)
  );

  coh_ser_datapath #(
    .ADDR_W   (ADDR_W),
    .LINE_OFS (LINE_OFS)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqAddr     (reqAddr),
    .strobes     (strobes),
    .heldLine    (heldLine),
    .hitHeld     (hitHeld),
    .reqSameLine (reqSameLine),
    .lineState   (lineState),
    .trackedLine (trackedLine)
  );

  assign m0ReqReady  = reqReady[0];
  assign m1ReqReady  = reqReady[1];
  assign m0RspValid  = rspValid[0];
  assign m1RspValid  = rspValid[1];
  assign m0SnpValid  = snpValid[0];
  assign m1SnpValid  = snpValid[1];
  // manager 0 is snooped on behalf of engine 1 and the reverse
  assign m0SnpAddr   = {heldLine[1], {LINE_OFS{1'b0}}};
  assign m1SnpAddr   = {heldLine[0], {LINE_OFS{1'b0}}};
  assign m0LineState = lineState[0];
  assign m1LineState = lineState[1];

endmodule

// File: rtl/coh_ser_checker.sv
module coh_ser_checker #(
  parameter int ADDR_W   = 32,
  parameter int LINE_OFS = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              m0ReqValid,
  input logic              m0ReqReady,
  input logic [ADDR_W-1:0] m0ReqAddr,
  input logic              m0RspValid,
  input logic              m0RspReady,
  input logic              m0SnpValid,
  input logic              m0SnpReady,
  input logic [ADDR_W-1:0] m0SnpAddr,
  input logic              m0SnpAck,
  input logic              m1ReqValid,
  input logic              m1ReqReady,
  input logic [ADDR_W-1:0] m1ReqAddr,
  input logic              m1RspValid,
  input logic              m1RspReady,
  input logic              m1SnpValid,
  input logic              m1SnpReady,
  input logic [ADDR_W-1:0] m1SnpAddr,
  input logic              m1SnpAck,
  input logic [1:0]        m0LineState,
  input logic [1:0]        m1LineState
);

  // R2
  sameLineOnce_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(m0ReqValid && m0ReqReady && m1ReqValid && m1ReqReady &&
      m0ReqAddr[ADDR_W-1:LINE_OFS] == m1ReqAddr[ADDR_W-1:LINE_OFS]));

  // R3
  singleUnique_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(m0LineState == 2'b10 && m1LineState == 2'b10));

  // R4
  snoopAfterGrant0_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m1SnpValid) |-> $past(m0ReqValid && m0ReqReady));

  // R4
  snoopAfterGrant1_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m0SnpValid) |-> $past(m1ReqValid && m1ReqReady));

  // R4
  snoopHold0_chk: assert property (@(posedge clk) disable iff (!rstN)
    m0SnpValid && !m0SnpReady |=> m0SnpValid && $stable(m0SnpAddr));

  // R4
  snoopHold1_chk: assert property (@(posedge clk) disable iff (!rstN)
    m1SnpValid && !m1SnpReady |=> m1SnpValid && $stable(m1SnpAddr));

  // R5
  rspAfterAck0_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m0RspValid) |-> $past(m1SnpAck));

  // R5
  rspAfterAck1_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m1RspValid) |-> $past(m0SnpAck));

  // R5
  rspHold0_chk: assert property (@(posedge clk) disable iff (!rstN)
    m0RspValid && !m0RspReady |=> m0RspValid);

  // R5
  rspHold1_chk: assert property (@(posedge clk) disable iff (!rstN)
    m1RspValid && !m1RspReady |=> m1RspValid);

  // R8
  ownerUpdate0_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m0RspValid) && !$rose(m1RspValid) |-> m0LineState == 2'b10 && m1LineState == 2'b00);

  // R8
  ownerUpdate1_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(m1RspValid) |-> m1LineState == 2'b10 && m0LineState == 2'b00);

endmodule

bind coh_line_serializer coh_ser_checker #(
  .ADDR_W   (ADDR_W),
  .LINE_OFS (LINE_OFS)
) chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .m0ReqValid  (m0ReqValid),
  .m0ReqReady  (m0ReqReady),
  .m0ReqAddr   (m0ReqAddr),
  .m0RspValid  (m0RspValid),
  .m0RspReady  (m0RspReady),
  .m0SnpValid  (m0SnpValid),
  .m0SnpReady  (m0SnpReady),
  .m0SnpAddr   (m0SnpAddr),
  .m0SnpAck    (m0SnpAck),
  .m1ReqValid  (m1ReqValid),
  .m1ReqReady  (m1ReqReady),
  .m1ReqAddr   (m1ReqAddr),
  .m1RspValid  (m1RspValid),
  .m1RspReady  (m1RspReady),
  .m1SnpValid  (m1SnpValid),
  .m1SnpReady  (m1SnpReady),
  .m1SnpAddr   (m1SnpAddr),
  .m1SnpAck    (m1SnpAck),
  .m0LineState (m0LineState),
  .m1LineState (m1LineState)
);

// File: tb/coh_line_serializer_tb_top.sv
module coh_line_serializer_tb_top;

  localparam int ADDR_W   = 32;
  localparam int LINE_OFS = 6;
  localparam int LINE_W   = ADDR_W - LINE_OFS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [1:0]        reqValid = '0, reqReady, rspValid, rspReady = '0;
  logic [1:0]        snpValid, snpReady = '0, snpAck = '0;
  logic [ADDR_W-1:0] reqAddr [2];
  logic [ADDR_W-1:0] snpAddr [2];
  logic [1:0]        lineState [2];
  logic [LINE_W-1:0] trackedLine;

  coh_line_serializer #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) dut_i (
    .clk(clk), .rstN(rstN),
    .m0ReqValid(reqValid[0]), .m0ReqReady(reqReady[0]), .m0ReqAddr(reqAddr[0]),
    .m0RspValid(rspValid[0]), .m0RspReady(rspReady[0]),
    .m0SnpValid(snpValid[0]), .m0SnpReady(snpReady[0]), .m0SnpAddr(snpAddr[0]),
    .m0SnpAck(snpAck[0]),
    .m1ReqValid(reqValid[1]), .m1ReqReady(reqReady[1]), .m1ReqAddr(reqAddr[1]),
    .m1RspValid(rspValid[1]), .m1RspReady(rspReady[1]),
    .m1SnpValid(snpValid[1]), .m1SnpReady(snpReady[1]), .m1SnpAddr(snpAddr[1]),
    .m1SnpAck(snpAck[1]),
    .m0LineState(lineState[0]), .m1LineState(lineState[1]),
    .trackedLine(trackedLine)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // bench model of each manager's request
  bit              outst [2];
  bit              ackSeen [2];
  logic [LINE_W-1:0] oLine [2];
  int              ackDelay [2];
  bit              wantReq [2];
  logic [ADDR_W-1:0] wantAddr [2];
  bit              gnt [2];
  bit              snpHs [2];
  logic [1:0]      expState [2];
  logic [LINE_W-1:0] expTrack;
  int              snpPct = 100;
  int              rspPct = 100;
  int              ackMax = 1;

  function automatic logic [LINE_W-1:0] lineOf(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:LINE_OFS];
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    // state after the previous edge
    for (int k = 0; k < 2; k++)
      check(lineState[k] == expState[k], "R8", $sformatf("state of manager %0d", k),
            lineState[k], expState[k]);
    check(trackedLine == expTrack, "R8", "tracked line", trackedLine, expTrack);
    check(!(lineState[0] == 2'b10 && lineState[1] == 2'b10), "R3", "both Unique",
          {lineState[1], lineState[0]}, 0);
    // drive new inputs
    for (int k = 0; k < 2; k++) begin
      if (gnt[k]) reqValid[k] = 1'b0;
      if (!reqValid[k] && !outst[k] && wantReq[k]) begin
        reqValid[k] = 1'b1;
        reqAddr[k]  = wantAddr[k];
        wantReq[k]  = 1'b0;
      end
      snpReady[k] = ($urandom % 100) < snpPct;
      rspReady[k] = ($urandom % 100) < rspPct;
      if (ackDelay[k] > 0) begin
        ackDelay[k]--;
        snpAck[k] = (ackDelay[k] == 0);
      end else begin
        snpAck[k] = 1'b0;
      end
    end
    #1;
    // responses (checked before this cycle's acks are credited)
    for (int k = 0; k < 2; k++) begin
      if (rspValid[k]) begin
        check(outst[k] && ackSeen[k], "R5", $sformatf("response %0d before ack", k),
              {outst[k], ackSeen[k]}, 2'b11);
        if (rspReady[k]) outst[k] = 1'b0;
      end
    end
    // acceptances
    for (int k = 0; k < 2; k++) begin
      gnt[k] = reqValid[k] && reqReady[k];
      if (gnt[k]) begin
        check(!(outst[1-k] && oLine[1-k] == lineOf(reqAddr[k])), "R2",
              $sformatf("manager %0d accepted on a held line", k), lineOf(reqAddr[k]), oLine[1-k]);
        outst[k]   = 1'b1;
        ackSeen[k] = 1'b0;
        oLine[k]   = lineOf(reqAddr[k]);
      end
    end
    // snoops seen by manager k come from manager 1-k's request
    for (int k = 0; k < 2; k++) begin
      snpHs[k] = 1'b0;
      if (snpValid[k]) begin
        check(outst[1-k] && !ackSeen[1-k] && snpAddr[k] == {oLine[1-k], {LINE_OFS{1'b0}}},
              "R4", $sformatf("snoop address to manager %0d", k), snpAddr[k],
              {oLine[1-k], {LINE_OFS{1'b0}}});
        if (snpReady[k]) begin
          snpHs[k]    = 1'b1;
          ackDelay[k] = 1 + ($urandom % ackMax);
        end
      end
    end
    // acks: manager 1 acks request 0 first, manager 0 acks request 1 last
    for (int e = 0; e < 2; e++) begin
      if (snpAck[1-e]) begin
        expState[e]   = 2'b10;
        expState[1-e] = 2'b00;
        expTrack      = oLine[e];
        ackSeen[e]    = 1'b1;
      end
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 400; i++) begin
      if (!outst[0] && !outst[1] && !wantReq[0] && !wantReq[1] &&
          !(reqValid[0] && !gnt[0]) && !(reqValid[1] && !gnt[1]) && ackDelay[0] == 0 && ackDelay[1] == 0)
        break;
      step();
    end
    check(!outst[0] && !outst[1], "R5", "requests left unfinished", {outst[1], outst[0]}, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    for (int k = 0; k < 2; k++) begin
      reqAddr[k] = '0; outst[k] = 0; ackSeen[k] = 0; oLine[k] = '0; ackDelay[k] = 0;
      wantReq[k] = 0; wantAddr[k] = '0; gnt[k] = 0; snpHs[k] = 0; expState[k] = 2'b00;
    end
    expTrack = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // reset state R9
    @(negedge clk);
    check(lineState[0] == 2'b00 && lineState[1] == 2'b00, "R9", "reset states",
          {lineState[1], lineState[0]}, 0);
    check(trackedLine == '0, "R9", "reset tracked line", trackedLine, 0);
    check(snpValid == 2'b00 && rspValid == 2'b00, "R9", "reset valids",
          {snpValid, rspValid}, 0);

    // tie on one line from reset: manager 0 wins (R6, R1 offsets ignored)
    wantReq[0] = 1; wantAddr[0] = 32'h1000;
    wantReq[1] = 1; wantAddr[1] = 32'h103C;
    step();
    check(gnt[0] && !gnt[1], "R6", "first tie winner", {gnt[1], gnt[0]}, 2'b01);
    check(!gnt[1], "R1", "offset-only difference treated as same line", gnt[1], 0);
    // stall while manager 0's upgrade is in flight (R2)
    for (int i = 0; i < 20 && outst[0]; i++) begin
      step();
      if (outst[0] || !gnt[1])
        check(!gnt[1], "R2", "stalled request accepted early", gnt[1], 0);
    end
    // resumes in the cycle after the response handshake (R10)
    if (!gnt[1]) step();
    check(gnt[1], "R10", "stalled request resumes", gnt[1], 1);
    step();
    check(snpValid[0] && snpAddr[0] == 32'h1000, "R10", "snoop to new owner",
          snpAddr[0], 32'h1000);
    drain();
    check(lineState[1] == 2'b10 && lineState[0] == 2'b00, "R8", "owner after resume",
          {lineState[1], lineState[0]}, 4'b1000);

    // different lines together; acks meet in one cycle (R7, R8 precedence)
    wantReq[0] = 1; wantAddr[0] = 32'h2000;
    wantReq[1] = 1; wantAddr[1] = 32'h2040;
    step();
    check(gnt[0] && gnt[1], "R7", "both lines accepted together", {gnt[1], gnt[0]}, 2'b11);
    drain();
    step();
    check(trackedLine == lineOf(32'h2040) && lineState[1] == 2'b10, "R8",
          "manager 1 wins same-cycle acks", trackedLine, lineOf(32'h2040));

    // lone grant passes priority, next tie goes to manager 1 (R6)
    wantReq[0] = 1; wantAddr[0] = 32'h3000;
    step();
    drain();
    wantReq[0] = 1; wantAddr[0] = 32'h3000;
    wantReq[1] = 1; wantAddr[1] = 32'h3010;
    step();
    check(gnt[1] && !gnt[0], "R6", "priority alternates", {gnt[1], gnt[0]}, 2'b10);
    drain();

    // random phase
    snpPct = 60; rspPct = 60; ackMax = 4;
    for (int i = 0; i < 4000; i++) begin
      for (int k = 0; k < 2; k++) begin
        if (!wantReq[k] && !outst[k] && !reqValid[k] && ($urandom % 3) == 0) begin
          wantReq[k] = 1;
          case ($urandom % 4)
            0: wantAddr[k] = 32'h1000 + ($urandom % 64);
            1: wantAddr[k] = 32'h1040 + ($urandom % 64);
            2: wantAddr[k] = 32'h1000;
            default: wantAddr[k] = 32'h7000 + (($urandom % 4) << 6);
          endcase
        end
      end
      step();
    end
    snpPct = 100; rspPct = 100;
    drain();

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule